// File: doc/BRIEF.md
# Stream Array Receiver with Packet Length Check

This block sits on the receiving end of a valid/ready word stream whose packets carry a variable number of fixed-size elements. Each element takes `WPE` consecutive words, and there is no padding between elements. The block passes every accepted word on, registered once, and marks the word that completes an element. At the end of every packet it pulses a done strobe together with the element count.

The block has two modes. In free-length mode, any packet length is accepted. The element count is taken from the number of words received, and a trailing fragment shorter than one element sets a partial-element flag.

In exact-count mode, the consumer must first arm the receiver with the number of elements it expects. No word is taken until then. The packet is then checked against the expected length of count times `WPE` words:
- If the last flag comes too soon, the early-last error is set.
- If the expected length is reached without a last flag, the missing-last error is set. The block then swallows words up to the last flag.

Error flags stay set until they are cleared or the receiver is armed again. `pull_mode_i` may only change between packets.

Top module: `stream_array_rx`

## Requirements
- R1: In free-length mode (`pull_mode_i`=0), `s_ready_o` is 1. On the word carrying `s_last_i`, `pkt_done_o` pulses for one cycle in the cycle after acceptance, and `pkt_elems_o` equals floor(words in packet / `WPE`).
- R2: In free-length mode, a packet whose word count is not a multiple of `WPE` sets `err_partial_o` in the same cycle as `pkt_done_o`. A packet whose count is a multiple of `WPE` does not set it.
- R3: Every accepted word that is not being discarded appears on `elem_data_o` with `elem_valid_o`=1 in the cycle after acceptance. `elem_end_o` is 1 for the WPE-th, 2·WPE-th, … word of the packet and 0 for all other words.
- R4: In exact-count mode, `s_ready_o` is 0 while the receiver is not armed, and words offered then are not accepted. An arm pulse with `arm_count_i`=0 is ignored.
- R5: In exact-count mode, a packet whose last flag falls on word `arm_count_i`·`WPE` gives `pkt_done_o` with `pkt_elems_o`=`arm_count_i` and no error. `s_ready_o` then drops to 0 until the next arm.
- R6: In exact-count mode, a last flag on an earlier word sets `err_early_o` and gives `pkt_done_o` with `pkt_elems_o` = floor(words received / `WPE`).
- R7: In exact-count mode, reaching word `arm_count_i`·`WPE` without a last flag sets `err_missing_o` the next cycle, with no `pkt_done_o`. Words that follow are accepted but discarded (`elem_valid_o`=0). The one carrying the last flag produces `pkt_done_o` with `pkt_elems_o`=`arm_count_i`.
- R8: The error flags are sticky. `clear_i` clears them, and so does an accepted arm. `err_early_o` and `err_missing_o` are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pull_mode_i | input | 1 | 1 = exact-count mode, 0 = free-length mode |
| arm_i | input | 1 | Arm pulse for exact-count mode |
| arm_count_i | input | CNT_W | Expected element count, taken with `arm_i` |
| clear_i | input | 1 | Clears the sticky error flags |
| s_valid_i | input | 1 | Input word valid |
| s_data_i | input | DATA_W | Input word |
| s_last_i | input | 1 | Last word of packet |
| s_ready_o | output | 1 | Input word ready |
| elem_valid_o | output | 1 | Element word valid |
| elem_data_o | output | DATA_W | Element word |
| elem_end_o | output | 1 | Word completes an element |
| pkt_done_o | output | 1 | End-of-packet pulse |
| pkt_elems_o | output | CNT_W | Element count of finished packet |
| err_early_o | output | 1 | Last flag before expected length |
| err_missing_o | output | 1 | No last flag at expected length |
| err_partial_o | output | 1 | Trailing partial element (free-length mode) |

## Verification
A wrong word index inside the element shows up within one cycle: `elem_end_o` lands on the wrong word, and `pkt_elems_o` is off at the next last flag. A wrong element counter only becomes visible at the end of the packet, either as a wrong count or as an early/missing error on a correctly sized packet. A wrong control state shows up at once on `s_ready_o`, for example ready while unarmed in exact-count mode. It can also show as elements presented during the discard phase, or as a packet end with no `pkt_done_o`.

// File: rtl/stream_array_rx_pkg.sv
package stream_array_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_DRAIN = 2'd2
  } srx_state_e;
endpackage

// File: rtl/srx_elem_track.sv
module srx_elem_track #(
  parameter int unsigned WPE   = 2,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  output logic             elem_end_o,
  output logic [CNT_W-1:0] count_next_o
);
  localparam int unsigned IDX_W = (WPE > 1) ? $clog2(WPE) : 1;

  logic [CNT_W-1:0] cnt_q;

  generate
    if (WPE > 1) begin : g_multi
      logic [IDX_W-1:0] idx_q;
      assign elem_end_o = (idx_q == IDX_W'(WPE - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          idx_q <= '0;
        end else if (clr_i) begin
          idx_q <= '0;
        end else if (step_i) begin
          idx_q <= elem_end_o ? '0 : idx_q + 1'b1;
        end
      end
    end else begin : g_single
      assign elem_end_o = 1'b1;
    end
  endgenerate

  assign count_next_o = cnt_q + CNT_W'(elem_end_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_i && elem_end_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import stream_array_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pull_mode_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] arm_count_i,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic             elem_end_i,
  input  logic [CNT_W-1:0] count_next_i,
  output logic             ready_o,
  output logic             deliver_o,
  output logic             trk_clr_o,
  output logic             done_o,
  output logic [CNT_W-1:0] done_count_o,
  output logic             err_early_o,
  output logic             err_missing_o,
  output logic             err_partial_o
);
  srx_state_e       state_q, state_d;
  logic [CNT_W-1:0] exp_q;
  logic             accept, arm_ok, hit;
  logic             done_d;
  logic [CNT_W-1:0] cnt_d;
  logic             set_early, set_missing, set_partial, clr_err;

  assign ready_o   = pull_mode_i ? (state_q != ST_IDLE) : 1'b1;
  assign accept    = valid_i && ready_o;
  assign deliver_o = accept && (state_q != ST_DRAIN);
  assign arm_ok    = pull_mode_i && (state_q == ST_IDLE) && arm_i && (arm_count_i != '0);
  // boundary reached: this word closes the requested number of elements
  assign hit       = elem_end_i && (count_next_i == exp_q);
  assign clr_err   = clear_i || arm_ok;

  always_comb begin
    state_d     = state_q;
    done_d      = 1'b0;
    cnt_d       = count_next_i;
    set_early   = 1'b0;
    set_missing = 1'b0;
    set_partial = 1'b0;
    trk_clr_o   = arm_ok;
    unique case (state_q)
      ST_IDLE: begin
        if (pull_mode_i) begin
          if (arm_ok) state_d = ST_RECV;
        end else if (deliver_o) begin
          if (last_i) begin
            done_d      = 1'b1;
            set_partial = !elem_end_i;
            trk_clr_o   = 1'b1;
          end else begin
            state_d = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (deliver_o) begin
          if (last_i) begin
            done_d    = 1'b1;
            trk_clr_o = 1'b1;
            state_d   = ST_IDLE;
            if (pull_mode_i) set_early = !hit;
            else             set_partial = !elem_end_i;
          end else if (pull_mode_i && hit) begin
            set_missing = 1'b1;
            trk_clr_o   = 1'b1;
            state_d     = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        cnt_d = exp_q;
        if (accept && last_i) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      exp_q         <= '0;
      done_o        <= 1'b0;
      done_count_o  <= '0;
      err_early_o   <= 1'b0;
      err_missing_o <= 1'b0;
      err_partial_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      if (arm_ok) exp_q <= arm_count_i;
      if (done_d) done_count_o <= cnt_d;
      err_early_o   <= (err_early_o   && !clr_err) || set_early;
      err_missing_o <= (err_missing_o && !clr_err) || set_missing;
      err_partial_o <= (err_partial_o && !clr_err) || set_partial;
    end
  end
endmodule

// File: rtl/stream_array_rx.sv
module stream_array_rx #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WPE    = 2,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pull_mode_i,
  input  logic              arm_i,
  input  logic [CNT_W-1:0]  arm_count_i,
  input  logic              clear_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              elem_valid_o,
  output logic [DATA_W-1:0] elem_data_o,
  output logic              elem_end_o,
  output logic              pkt_done_o,
  output logic [CNT_W-1:0]  pkt_elems_o,
  output logic              err_early_o,
  output logic              err_missing_o,
  output logic              err_partial_o
);
  logic             deliver, trk_clr, elem_end;
  logic [CNT_W-1:0] count_next;

  srx_elem_track #(
    .WPE   (WPE),
    .CNT_W (CNT_W)
  ) i_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (deliver),
    .clr_i        (trk_clr),
    .elem_end_o   (elem_end),
    .count_next_o (count_next)
  );

  srx_ctrl #(
    .CNT_W (CNT_W)
  ) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pull_mode_i   (pull_mode_i),
    .arm_i         (arm_i),
    .arm_count_i   (arm_count_i),
    .clear_i       (clear_i),
    .valid_i       (s_valid_i),
    .last_i        (s_last_i),
    .elem_end_i    (elem_end),
    .count_next_i  (count_next),
    .ready_o       (s_ready_o),
    .deliver_o     (deliver),
    .trk_clr_o     (trk_clr),
    .done_o        (pkt_done_o),
    .done_count_o  (pkt_elems_o),
    .err_early_o   (err_early_o),
    .err_missing_o (err_missing_o),
    .err_partial_o (err_partial_o)
  );

  // single word output stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elem_valid_o <= 1'b0;
      elem_end_o   <= 1'b0;
      elem_data_o  <= '0;
    end else begin
      elem_valid_o <= deliver;
      elem_end_o   <= deliver && elem_end;
      if (deliver) elem_data_o <= s_data_i;
    end
  end
endmodule

// File: rtl/stream_array_rx_chk.sv
module stream_array_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pull_mode_i,
  input logic arm_i,
  input logic clear_i,
  input logic s_valid_i,
  input logic s_ready_o,
  input logic elem_valid_o,
  input logic elem_end_o,
  input logic pkt_done_o,
  input logic err_early_o,
  input logic err_missing_o,
  input logic err_partial_o
);
  p_end_in_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_end_o |-> elem_valid_o);

  p_valid_from_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o |-> $past(s_valid_i && s_ready_o));

  p_unarmed_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_o && pull_mode_i) |-> !s_ready_o);

  p_missing_no_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_missing_o) |-> !pkt_done_o);

  p_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_early_o && err_missing_o));

  p_partial_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_partial_o && !clear_i && !arm_i) |=> err_partial_o);

  p_push_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pull_mode_i |-> s_ready_o);
endmodule

bind stream_array_rx stream_array_rx_chk i_stream_array_rx_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pull_mode_i   (pull_mode_i),
  .arm_i         (arm_i),
  .clear_i       (clear_i),
  .s_valid_i     (s_valid_i),
  .s_ready_o     (s_ready_o),
  .elem_valid_o  (elem_valid_o),
  .elem_end_o    (elem_end_o),
  .pkt_done_o    (pkt_done_o),
  .err_early_o   (err_early_o),
  .err_missing_o (err_missing_o),
  .err_partial_o (err_partial_o)
);

// File: tb/test_stream_array_rx.sv
`timescale 1ns/1ps
module test_stream_array_rx;
  localparam int DATA_W = 32;
  localparam int WPE    = 2;
  localparam int CNT_W  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              pull_mode_i = 1'b0;
  logic              arm_i = 1'b0;
  logic [CNT_W-1:0]  arm_count_i = '0;
  logic              clear_i = 1'b0;
  logic              s_valid_i = 1'b0;
  logic [DATA_W-1:0] s_data_i = '0;
  logic              s_last_i = 1'b0;
  logic              s_ready_o;
  logic              elem_valid_o;
  logic [DATA_W-1:0] elem_data_o;
  logic              elem_end_o;
  logic              pkt_done_o;
  logic [CNT_W-1:0]  pkt_elems_o;
  logic              err_early_o, err_missing_o, err_partial_o;

  int n_chk = 0;
  int n_fail = 0;
  logic rdy_seen;

  always #10 clk_i = ~clk_i;

  stream_array_rx #(.DATA_W(DATA_W), .WPE(WPE), .CNT_W(CNT_W)) i_stream_array_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .pull_mode_i(pull_mode_i), .arm_i(arm_i),
    .arm_count_i(arm_count_i), .clear_i(clear_i), .s_valid_i(s_valid_i),
    .s_data_i(s_data_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
    .elem_valid_o(elem_valid_o), .elem_data_o(elem_data_o), .elem_end_o(elem_end_o),
    .pkt_done_o(pkt_done_o), .pkt_elems_o(pkt_elems_o), .err_early_o(err_early_o),
    .err_missing_o(err_missing_o), .err_partial_o(err_partial_o)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one word; outputs sampled 1 ns after the accepting edge
  task automatic send(input logic [DATA_W-1:0] d, input logic l);
    @(negedge clk_i);
    s_valid_i = 1'b1; s_data_i = d; s_last_i = l;
    #1 rdy_seen = s_ready_o;
    @(posedge clk_i);
    #1;
    @(negedge clk_i);
    s_valid_i = 1'b0; s_last_i = 1'b0;
  endtask

  // word whose output stage is checked right after acceptance
  task automatic send_chk(input string req, input logic [DATA_W-1:0] d, input logic l,
                          input logic exp_valid, input logic exp_end, input logic exp_done);
    @(negedge clk_i);
    s_valid_i = 1'b1; s_data_i = d; s_last_i = l;
    @(posedge clk_i);
    #1;
    check(req, "elem_valid", elem_valid_o, exp_valid);
    if (exp_valid) check(req, "elem_data", elem_data_o, d);
    check(req, "elem_end", elem_end_o, exp_end);
    check(req, "pkt_done", pkt_done_o, exp_done);
    @(negedge clk_i);
    s_valid_i = 1'b0; s_last_i = 1'b0;
  endtask

  task automatic arm(input int cnt);
    @(negedge clk_i);
    arm_i = 1'b1; arm_count_i = CNT_W'(cnt);
    @(negedge clk_i);
    arm_i = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "ready after reset", s_ready_o, 1);
    check("R3", "elem_valid after reset", elem_valid_o, 0);
    check("R1", "done after reset", pkt_done_o, 0);
    check("R8", "errors after reset", {err_early_o, err_missing_o, err_partial_o}, 0);
  endtask

  task automatic t_push_full();
    for (int i = 0; i < 6; i++)
      send_chk("R3", 32'hA000 + i, i == 5, 1'b1, (i % 2) == 1, i == 5);
    check("R1", "push count 6 words", pkt_elems_o, 3);
    check("R2", "no partial on full packet", err_partial_o, 0);
    @(negedge clk_i);
    check("R1", "done is one pulse", pkt_done_o, 0);
  endtask

  task automatic t_push_single_word();
    send_chk("R1", 32'h55, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R1", "count of one-word packet", pkt_elems_o, 0);
    check("R2", "partial on one-word packet", err_partial_o, 1);
    do_clear();
    check("R8", "clear drops partial", err_partial_o, 0);
  endtask

  task automatic t_push_partial();
    for (int i = 0; i < 5; i++)
      send_chk("R2", 32'hB000 + i, i == 4, 1'b1, (i % 2) == 1, i == 4);
    check("R1", "push count 5 words", pkt_elems_o, 2);
    check("R2", "partial set", err_partial_o, 1);
    for (int i = 0; i < 2; i++) send(32'hC000 + i, i == 1);
    check("R8", "partial sticky over clean packet", err_partial_o, 1);
    do_clear();
    check("R8", "clear drops partial", err_partial_o, 0);
  endtask

  task automatic t_pull_unarmed();
    pull_mode_i = 1'b1;
    @(negedge clk_i);
    check("R4", "ready low unarmed", s_ready_o, 0);
    send_chk("R4", 32'hDEAD, 1'b1, 1'b0, 1'b0, 1'b0);
    arm(0);
    check("R4", "zero arm ignored", s_ready_o, 0);
  endtask

  task automatic t_pull_exact();
    arm(2);
    check("R4", "ready after arm", s_ready_o, 1);
    for (int i = 0; i < 4; i++)
      send_chk("R5", 32'hE000 + i, i == 3, 1'b1, (i % 2) == 1, i == 3);
    check("R5", "exact count", pkt_elems_o, 2);
    check("R5", "no errors", {err_early_o, err_missing_o, err_partial_o}, 0);
    check("R5", "ready low after packet", s_ready_o, 0);
  endtask

  task automatic t_pull_early();
    arm(3);
    for (int i = 0; i < 3; i++)
      send_chk("R6", 32'hF000 + i, i == 2, 1'b1, (i % 2) == 1, i == 2);
    check("R6", "early flag", err_early_o, 1);
    check("R6", "early count floor", pkt_elems_o, 1);
    check("R6", "no missing flag", err_missing_o, 0);
  endtask

  task automatic t_pull_missing();
    arm(2);
    check("R8", "arm clears early flag", err_early_o, 0);
    for (int i = 0; i < 4; i++)
      send_chk("R7", 32'h1000 + i, 1'b0, 1'b1, (i % 2) == 1, 1'b0);
    check("R7", "missing flag", err_missing_o, 1);
    send_chk("R7", 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7", "ready while discarding", rdy_seen | s_ready_o, 1);
    send_chk("R7", 32'h2001, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7", "count after discard", pkt_elems_o, 2);
    check("R8", "no early with missing", err_early_o, 0);
    check("R7", "ready low after drain", s_ready_o, 0);
    arm(1);
    check("R8", "arm clears missing flag", err_missing_o, 0);
    send_chk("R5", 32'h3000, 1'b0, 1'b1, 1'b0, 1'b0);
    send_chk("R5", 32'h3001, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5", "one element exact", pkt_elems_o, 1);
    pull_mode_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_push_full();
        t_push_single_word();
        t_push_partial();
        t_pull_unarmed();
        t_pull_exact();
        t_pull_early();
        t_pull_missing();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule